// File: doc/BRIEF.md
# Flash Byte-Program and Erase Controller with Status Polling

This block sits on the host side of an asynchronous parallel flash bus. A single request starts one of three jobs: writing one byte, erasing one sector, or erasing the entire array. The controller generates the unlock-and-command write cycles, then reads the device back repeatedly. From those status reads it decides whether the embedded operation finished cleanly, without using a ready/busy pin.

Two polling methods are available, chosen per request. The toggle method compares bit 6 of two back-to-back reads. The data method compares bit 7 of a read against the value it should finally hold. In both methods, seeing bit 5 set triggers one confirming round before the result is declared. When the verdict is a failure, the controller issues a read-mode reset write to the device before reporting. All pulse widths and recovery gaps are counted in clock cycles.

Top module: `flash_prog_ctrl`

## Requirements
- R1: When `opCode` is 00 (program), exactly four write cycles are issued, as address/data pairs in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then `opAddr`/`opData`.
- R2: A sector erase (`opCode` 01) and a chip erase (`opCode` 1x) each issue six writes: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55. The sixth write is `opAddr`/0x30 for a sector erase and 0x555/0x10 for a chip erase.
- R3: Each WE low pulse lasts at least WE_LOW_CYC clocks. Between writes of one sequence, WE stays high for at least WE_HIGH_CYC clocks. CE is low whenever WE is low. Data is driven only while OE is high.
- R4: WE never falls until OE has been high for at least OE_WE_GAP_CYC clocks, and WE and OE are never both low.
- R5: Toggle method (`pollToggle`=1): status is read in pairs. If bit 6 is equal in both reads of a pair, the result is pass.
- R6: Toggle method: if bit 6 differs within a pair and bit 5 of the second read is 1, one more pair is read. The result is pass if bit 6 is equal in that pair and fail otherwise.
- R7: Data method (`pollToggle`=0): a read whose bit 7 equals the expected value gives pass. The expected value is 1 for either erase and `opData` bit 7 for a program.
- R8: Data method: if bit 7 does not match and bit 5 is 1, one more read is made. A match on that read gives pass; a mismatch gives fail.
- R9: Every failure writes data 0xF0 to the device (address 0) as its last bus write before completion. A pass issues no such write.
- R10: A failure is forced after POLL_LIMIT consecutive inconclusive polls. An inconclusive poll is a pair with bit 6 differing, or a read with bit 7 mismatched, where bit 5 is 0.
- R11: After reset, CE, WE and OE are high, the data driver is off and `opDone` is low. `opDone` pulses for one clock with `opPass` valid. `startReq` has no effect while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start an operation (taken only when idle) |
| opCode | input | 2 | 00 program, 01 sector erase, 1x chip erase |
| opAddr | input | ADDR_W | Byte address or sector address; also used for status reads |
| opData | input | 8 | Byte to program |
| pollToggle | input | 1 | 1 selects the toggle method, 0 the data method |
| flashDin | input | 8 | Data read from the device |
| opDone | output | 1 | One-cycle completion pulse |
| opPass | output | 1 | Verdict, valid with `opDone` |
| flashCeN | output | 1 | Chip enable, active low |
| flashWeN | output | 1 | Write enable, active low |
| flashOeN | output | 1 | Output enable, active low |
| flashAddr | output | ADDR_W | Device address |
| flashDout | output | 8 | Data driven to the device |
| flashDoutEn | output | 1 | Enable for the data driver |

## Verification
The hardest cases to reach are the confirming rounds. In these, bit 5 rises while the device is still busy, and the busy period then ends exactly between the first read and the confirming read. Which verdict results depends on which read index the busy period ends at. The bench's device model replies to each OE fall with a status byte computed from the read index, a busy length and the index at which bit 5 rises. Sweeping the busy length across every read index, with bit 5 rising early, late or never, places the end of the busy period at every position in the algorithm for both methods and all three operations. Busy lengths longer than POLL_LIMIT drive the forced failure.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  localparam logic [11:0] UNLOCK_ADDR_A = 12'h555;
  localparam logic [11:0] UNLOCK_ADDR_B = 12'h2AA;

  localparam logic [7:0] CMD_KEY_A      = 8'hAA;
  localparam logic [7:0] CMD_KEY_B      = 8'h55;
  localparam logic [7:0] CMD_PROG_SETUP = 8'hA0;
  localparam logic [7:0] CMD_ERASE_SET  = 8'h80;
  localparam logic [7:0] CMD_ERASE_ALL  = 8'h10;
  localparam logic [7:0] CMD_ERASE_SECT = 8'h30;
  localparam logic [7:0] CMD_READ_MODE  = 8'hF0;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_WLO  = 2'd1,
    BUS_WHI  = 2'd2,
    BUS_READ = 2'd3
  } busPhase_t;

  typedef struct packed {
    logic      opLatch;
    logic      sampleCap;
    logic      pollClr;
    logic      pollInc;
    logic      passSet;
    logic      passClr;
    busPhase_t busPhase;
    logic [2:0] wrSel;
    logic      resetWr;
  } ctrlStrobe_t;

endpackage

// File: rtl/fpc_datapath.sv
module fpc_datapath
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int WE_LOW_CYC    = 3,
  parameter int WE_HIGH_CYC   = 2,
  parameter int OE_WE_GAP_CYC = 1,
  parameter int POLL_LIMIT    = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [1:0]        startCode,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        startData,
  input  logic              startToggle,
  input  logic [7:0]        flashDin,
  output logic              toggleMode,
  output logic              wrLast,
  output logic              bit6Same,
  output logic              bit5Seen,
  output logic              bit7Hit,
  output logic              pollExpired,
  output logic              passFlag,
  output logic              flashCeN,
  output logic              flashWeN,
  output logic              flashOeN,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashDout,
  output logic              flashDoutEn
);

  localparam int POLL_W  = $clog2(POLL_LIMIT + 1);
  localparam int RUN_MAX = (WE_LOW_CYC > WE_HIGH_CYC ? WE_LOW_CYC : WE_HIGH_CYC) > OE_WE_GAP_CYC ?
                           (WE_LOW_CYC > WE_HIGH_CYC ? WE_LOW_CYC : WE_HIGH_CYC) : OE_WE_GAP_CYC;
  localparam int RUN_W   = $clog2(RUN_MAX + 2) + 1;

  logic [ADDR_W-1:0] opAddrQ;
  logic [7:0]        opDataQ;
  logic [1:0]        opCodeQ;
  logic              toggleQ;
  logic [7:0]        curS, prevS;
  logic [POLL_W-1:0] pollCnt;
  logic              passQ;

  logic              isProg, isChip, expBit7;
  logic [ADDR_W-1:0] wrAddr;
  logic [7:0]        wrData;

  assign isProg  = (opCodeQ == 2'b00);
  assign isChip  = opCodeQ[1];
  assign expBit7 = isProg ? opDataQ[7] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAddrQ <= '0;
      opDataQ <= '0;
      opCodeQ <= '0;
      toggleQ <= 1'b0;
      curS    <= '0;
      prevS   <= '0;
      pollCnt <= '0;
      passQ   <= 1'b0;
    end else begin
      if (strobe.opLatch) begin
        opAddrQ <= startAddr;
        opDataQ <= startData;
        opCodeQ <= startCode;
        toggleQ <= startToggle;
      end
      if (strobe.sampleCap) begin
        prevS <= curS;
        curS  <= flashDin;
      end
      if (strobe.pollClr)      pollCnt <= '0;
      else if (strobe.pollInc) pollCnt <= pollCnt + 1'b1;
      if (strobe.passClr)      passQ <= 1'b0;
      else if (strobe.passSet) passQ <= 1'b1;
    end
  end

  // command table: one address/data pair per write slot
  always_comb begin
    wrAddr = '0;
    wrData = CMD_READ_MODE;
    if (!strobe.resetWr) begin
      case (strobe.wrSel)
        3'd0: begin wrAddr = ADDR_W'(UNLOCK_ADDR_A); wrData = CMD_KEY_A; end
        3'd1: begin wrAddr = ADDR_W'(UNLOCK_ADDR_B); wrData = CMD_KEY_B; end
        3'd2: begin
          wrAddr = ADDR_W'(UNLOCK_ADDR_A);
          wrData = isProg ? CMD_PROG_SETUP : CMD_ERASE_SET;
        end
        3'd3: begin
          if (isProg) begin wrAddr = opAddrQ; wrData = opDataQ; end
          else begin wrAddr = ADDR_W'(UNLOCK_ADDR_A); wrData = CMD_KEY_A; end
        end
        3'd4: begin wrAddr = ADDR_W'(UNLOCK_ADDR_B); wrData = CMD_KEY_B; end
        default: begin
          if (isChip) begin wrAddr = ADDR_W'(UNLOCK_ADDR_A); wrData = CMD_ERASE_ALL; end
          else begin wrAddr = opAddrQ; wrData = CMD_ERASE_SECT; end
        end
      endcase
    end
  end

  assign wrLast      = strobe.resetWr | (isProg ? (strobe.wrSel == 3'd3) : (strobe.wrSel == 3'd5));
  assign toggleMode  = toggleQ;
  assign bit6Same    = (curS[6] == prevS[6]);
  assign bit5Seen    = curS[5];
  assign bit7Hit     = (curS[7] == expBit7);
  assign pollExpired = (pollCnt == POLL_W'(POLL_LIMIT - 1));
  assign passFlag    = passQ;

  always_comb begin
    flashCeN    = 1'b1;
    flashWeN    = 1'b1;
    flashOeN    = 1'b1;
    flashDoutEn = 1'b0;
    flashAddr   = '0;
    flashDout   = wrData;
    case (strobe.busPhase)
      BUS_WLO: begin
        flashCeN = 1'b0; flashWeN = 1'b0; flashDoutEn = 1'b1; flashAddr = wrAddr;
      end
      BUS_WHI: begin
        flashCeN = 1'b0; flashDoutEn = 1'b1; flashAddr = wrAddr;
      end
      BUS_READ: begin
        flashCeN = 1'b0; flashOeN = 1'b0; flashAddr = opAddrQ;
      end
      default: ;
    endcase
  end

  // run-length monitors for the bus timing checks
  logic [RUN_W-1:0] weLowRun, weHighRun, oeHighRun;
  localparam logic [RUN_W-1:0] RUN_SAT = {RUN_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weLowRun  <= '0;
      weHighRun <= '0;
      oeHighRun <= RUN_SAT;
    end else begin
      weLowRun  <= flashWeN ? '0 : (weLowRun == RUN_SAT ? RUN_SAT : weLowRun + 1'b1);
      weHighRun <= !flashWeN ? '0 : (weHighRun == RUN_SAT ? RUN_SAT : weHighRun + 1'b1);
      oeHighRun <= !flashOeN ? '0 : (oeHighRun == RUN_SAT ? RUN_SAT : oeHighRun + 1'b1);
    end
  end

  assert_we_low_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWeN) |-> weLowRun >= RUN_W'(WE_LOW_CYC));

  assert_we_high_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(flashWeN) && $past(!flashCeN)) |-> weHighRun >= RUN_W'(WE_HIGH_CYC));

  assert_ce_covers_we_R3: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> !flashCeN);

  assert_drive_only_oe_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    flashDoutEn |-> flashOeN);

  assert_oe_to_we_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashWeN) |-> oeHighRun >= RUN_W'(OE_WE_GAP_CYC));

  assert_no_we_oe_overlap_R4: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> flashOeN);

  assert_poll_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < POLL_W'(POLL_LIMIT));

endmodule

// File: rtl/fpc_control.sv
module fpc_control
  import flash_prog_pkg::*;
#(
  parameter int WE_LOW_CYC    = 3,
  parameter int WE_HIGH_CYC   = 2,
  parameter int OE_LOW_CYC    = 3,
  parameter int OE_WE_GAP_CYC = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        toggleMode,
  input  logic        wrLast,
  input  logic        bit6Same,
  input  logic        bit5Seen,
  input  logic        bit7Hit,
  input  logic        pollExpired,
  input  logic        passFlag,
  output ctrlStrobe_t strobe,
  output logic        opDone
);

  localparam int MAX_A   = WE_LOW_CYC > WE_HIGH_CYC ? WE_LOW_CYC : WE_HIGH_CYC;
  localparam int MAX_B   = OE_LOW_CYC > OE_WE_GAP_CYC ? OE_LOW_CYC : OE_WE_GAP_CYC;
  localparam int MAX_LEN = MAX_A > MAX_B ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  localparam logic [CNT_W-1:0] LEN_WLO = CNT_W'(WE_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] LEN_WHI = CNT_W'(WE_HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] LEN_RLO = CNT_W'(OE_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] LEN_GAP = CNT_W'(OE_WE_GAP_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WLO, S_WHI, S_RLO, S_RGAP, S_DONE
  } state_t;

  state_t           stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic [2:0]       wrIdxQ, wrIdxD;
  logic             resetWrQ, resetWrD;
  logic [1:0]       phaseQ, phaseD;

  logic phaseEnd;
  logic goPass, goFail, goRead;
  logic [1:0] nextPhase;

  assign phaseEnd = (cntQ == '0);

  // verdict after each status read, from the sampled bits
  always_comb begin
    goPass    = 1'b0;
    goFail    = 1'b0;
    goRead    = 1'b0;
    nextPhase = 2'd0;
    if (toggleMode) begin
      case (phaseQ)
        2'd0: begin goRead = 1'b1; nextPhase = 2'd1; end
        2'd1: begin
          if (bit6Same)         goPass = 1'b1;
          else if (bit5Seen)    begin goRead = 1'b1; nextPhase = 2'd2; end
          else if (pollExpired) goFail = 1'b1;
          else                  begin goRead = 1'b1; nextPhase = 2'd0; end
        end
        2'd2: begin goRead = 1'b1; nextPhase = 2'd3; end
        default: begin
          if (bit6Same) goPass = 1'b1;
          else          goFail = 1'b1;
        end
      endcase
    end else begin
      if (phaseQ == 2'd0) begin
        if (bit7Hit)          goPass = 1'b1;
        else if (bit5Seen)    begin goRead = 1'b1; nextPhase = 2'd1; end
        else if (pollExpired) goFail = 1'b1;
        else                  begin goRead = 1'b1; nextPhase = 2'd0; end
      end else begin
        if (bit7Hit) goPass = 1'b1;
        else         goFail = 1'b1;
      end
    end
  end

  always_comb begin
    stateD   = stateQ;
    cntD     = phaseEnd ? '0 : cntQ - 1'b1;
    wrIdxD   = wrIdxQ;
    resetWrD = resetWrQ;
    phaseD   = phaseQ;
    strobe   = '0;
    strobe.wrSel   = wrIdxQ;
    strobe.resetWr = resetWrQ;
    case (stateQ)
      S_WLO:   strobe.busPhase = BUS_WLO;
      S_WHI:   strobe.busPhase = BUS_WHI;
      S_RLO:   strobe.busPhase = BUS_READ;
      default: strobe.busPhase = BUS_IDLE;
    endcase

    case (stateQ)
      S_IDLE: begin
        if (startReq) begin
          strobe.opLatch = 1'b1;
          strobe.pollClr = 1'b1;
          strobe.passClr = 1'b1;
          wrIdxD   = 3'd0;
          resetWrD = 1'b0;
          stateD   = S_WLO;
          cntD     = LEN_WLO;
        end
      end
      S_WLO: begin
        if (phaseEnd) begin
          stateD = S_WHI;
          cntD   = LEN_WHI;
        end
      end
      S_WHI: begin
        if (phaseEnd) begin
          if (resetWrQ) begin
            stateD = S_DONE;
          end else if (wrLast) begin
            stateD = S_RLO;
            cntD   = LEN_RLO;
            phaseD = 2'd0;
          end else begin
            wrIdxD = wrIdxQ + 3'd1;
            stateD = S_WLO;
            cntD   = LEN_WLO;
          end
        end
      end
      S_RLO: begin
        if (phaseEnd) begin
          strobe.sampleCap = 1'b1;
          stateD = S_RGAP;
          cntD   = LEN_GAP;
        end
      end
      S_RGAP: begin
        if (phaseEnd) begin
          if (goPass) begin
            strobe.passSet = 1'b1;
            stateD = S_DONE;
          end else if (goFail) begin
            resetWrD = 1'b1;
            stateD   = S_WLO;
            cntD     = LEN_WLO;
          end else if (goRead) begin
            strobe.pollInc = (nextPhase == 2'd0);
            phaseD = nextPhase;
            stateD = S_RLO;
            cntD   = LEN_RLO;
          end
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      cntQ     <= '0;
      wrIdxQ   <= '0;
      resetWrQ <= 1'b0;
      phaseQ   <= '0;
    end else begin
      stateQ   <= stateD;
      cntQ     <= cntD;
      wrIdxQ   <= wrIdxD;
      resetWrQ <= resetWrD;
      phaseQ   <= phaseD;
    end
  end

  assign opDone = (stateQ == S_DONE);

  assert_done_single_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone);

  assert_fail_after_reset_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && !passFlag) |-> $past(stateQ == S_WHI && resetWrQ));

  assert_pass_without_reset_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && passFlag) |-> $past(stateQ == S_RGAP));

  assert_start_ignored_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != S_IDLE && stateQ != S_DONE) |=> stateQ != S_IDLE);

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int WE_LOW_CYC    = 3,
  parameter int WE_HIGH_CYC   = 2,
  parameter int OE_LOW_CYC    = 3,
  parameter int OE_WE_GAP_CYC = 1,
  parameter int POLL_LIMIT    = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [1:0]        opCode,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [7:0]        opData,
  input  logic              pollToggle,
  input  logic [7:0]        flashDin,
  output logic              opDone,
  output logic              opPass,
  output logic              flashCeN,
  output logic              flashWeN,
  output logic              flashOeN,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashDout,
  output logic              flashDoutEn
);

  ctrlStrobe_t strobe;
  logic toggleMode, wrLast, bit6Same, bit5Seen, bit7Hit, pollExpired, passFlag;

  fpc_control #(
    .WE_LOW_CYC   (WE_LOW_CYC),
    .WE_HIGH_CYC  (WE_HIGH_CYC),
    .OE_LOW_CYC   (OE_LOW_CYC),
    .OE_WE_GAP_CYC(OE_WE_GAP_CYC)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .toggleMode (toggleMode),
    .wrLast     (wrLast),
    .bit6Same   (bit6Same),
    .bit5Seen   (bit5Seen),
    .bit7Hit    (bit7Hit),
    .pollExpired(pollExpired),
    .passFlag   (passFlag),
    .strobe     (strobe),
    .opDone     (opDone)
  );

  fpc_datapath #(
    .ADDR_W       (ADDR_W),
    .WE_LOW_CYC   (WE_LOW_CYC),
    .WE_HIGH_CYC  (WE_HIGH_CYC),
    .OE_WE_GAP_CYC(OE_WE_GAP_CYC),
    .POLL_LIMIT   (POLL_LIMIT)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .startCode  (opCode),
    .startAddr  (opAddr),
    .startData  (opData),
    .startToggle(pollToggle),
    .flashDin   (flashDin),
    .toggleMode (toggleMode),
    .wrLast     (wrLast),
    .bit6Same   (bit6Same),
    .bit5Seen   (bit5Seen),
    .bit7Hit    (bit7Hit),
    .pollExpired(pollExpired),
    .passFlag   (passFlag),
    .flashCeN   (flashCeN),
    .flashWeN   (flashWeN),
    .flashOeN   (flashOeN),
    .flashAddr  (flashAddr),
    .flashDout  (flashDout),
    .flashDoutEn(flashDoutEn)
  );

  assign opPass = passFlag;

endmodule

// File: tb/flash_prog_ctrl_bench.sv
module flash_prog_ctrl_bench;

  localparam int ADDR_W = 19;
  localparam int WLO    = 3;
  localparam int WHI    = 2;
  localparam int OLO    = 3;
  localparam int GAP    = 1;
  localparam int LIMIT  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [1:0] opCode = '0;
  logic [ADDR_W-1:0] opAddr = '0;
  logic [7:0] opData = '0;
  logic pollToggle = 1'b0;
  logic [7:0] flashDin = '0;
  logic opDone, opPass, flashCeN, flashWeN, flashOeN, flashDoutEn;
  logic [ADDR_W-1:0] flashAddr;
  logic [7:0] flashDout;

  always #10 clk = ~clk;

  flash_prog_ctrl #(
    .ADDR_W(ADDR_W), .WE_LOW_CYC(WLO), .WE_HIGH_CYC(WHI),
    .OE_LOW_CYC(OLO), .OE_WE_GAP_CYC(GAP), .POLL_LIMIT(LIMIT)
  ) u_flash_prog_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opCode(opCode), .opAddr(opAddr),
    .opData(opData), .pollToggle(pollToggle), .flashDin(flashDin), .opDone(opDone),
    .opPass(opPass), .flashCeN(flashCeN), .flashWeN(flashWeN), .flashOeN(flashOeN),
    .flashAddr(flashAddr), .flashDout(flashDout), .flashDoutEn(flashDoutEn)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // device model: status byte depends on the read index
  int busy = 0;
  int dq5At = 99;
  logic exp7 = 1'b1;
  logic [7:0] finalVal = 8'hFF;
  int readIdx = 0;
  int wrCnt = 0;
  logic [ADDR_W-1:0] wrA [16];
  logic [7:0] wrD [16];
  logic prevOe = 1'b1, prevWe = 1'b1;
  logic [ADDR_W-1:0] lastA = '0;
  logic [7:0] lastD = '0;

  int weLowRun = 0, weHighRun = 0, oeHighRun = 100;
  int minWeLow = 1000, minWeHigh = 1000, minGap = 1000;
  int badDrive = 0, badOverlap = 0, badCe = 0;

  function automatic logic [7:0] devVal(input int k);
    if (k < busy) return {~exp7, k[0], (k >= dq5At), 5'b0};
    return finalVal;
  endfunction

  always @(negedge clk) begin
    if (prevOe && !flashOeN) begin
      flashDin <= devVal(readIdx);
      readIdx  <= readIdx + 1;
    end
    if (!flashWeN) begin
      lastA <= flashAddr;
      lastD <= flashDout;
    end
    if (!prevWe && flashWeN && wrCnt < 16) begin
      wrA[wrCnt] <= lastA;
      wrD[wrCnt] <= lastD;
      wrCnt <= wrCnt + 1;
    end
    if (!flashWeN && prevWe) begin
      if (oeHighRun < minGap) minGap = oeHighRun;
      if (weHighRun > 0 && weHighRun < minWeHigh) minWeHigh = weHighRun;
    end
    if (flashWeN && !prevWe && weLowRun < minWeLow) minWeLow = weLowRun;
    weLowRun  = flashWeN ? 0 : weLowRun + 1;
    weHighRun = (flashWeN && !flashCeN) ? weHighRun + 1 : 0;
    oeHighRun = flashOeN ? oeHighRun + 1 : 0;
    if (flashDoutEn && !flashOeN) badDrive++;
    if (!flashWeN && !flashOeN) badOverlap++;
    if (!flashWeN && flashCeN) badCe++;
    prevOe = flashOeN;
    prevWe = flashWeN;
  end

  task automatic expectWrite(input int op, input int idx, input logic [ADDR_W-1:0] a,
                             input logic [7:0] d, output logic [ADDR_W-1:0] ea, output logic [7:0] ed);
    ea = 'h555; ed = 8'hAA;
    case (idx)
      1: begin ea = 'h2AA; ed = 8'h55; end
      2: ed = (op == 0) ? 8'hA0 : 8'h80;
      3: if (op == 0) begin ea = a; ed = d; end
      4: begin ea = 'h2AA; ed = 8'h55; end
      5: if (op == 1) begin ea = a; ed = 8'h30; end else ed = 8'h10;
      default: ;
    endcase
  endtask

  task automatic predict(input bit tog, output bit pass, output int reads, output string tag);
    int k = 0;
    int polls = 0;
    logic [7:0] a, b;
    pass = 0;
    tag = "R10";
    while (1) begin
      if (tog) begin
        a = devVal(k); b = devVal(k + 1); k += 2;
        if (a[6] == b[6]) begin pass = 1; tag = "R5"; break; end
        if (b[5]) begin
          a = devVal(k); b = devVal(k + 1); k += 2;
          pass = (a[6] == b[6]); tag = "R6"; break;
        end
      end else begin
        a = devVal(k); k += 1;
        if (a[7] == exp7) begin pass = 1; tag = "R7"; break; end
        if (a[5]) begin
          a = devVal(k); k += 1;
          pass = (a[7] == exp7); tag = "R8"; break;
        end
      end
      polls++;
      if (polls >= LIMIT) begin pass = 0; tag = "R10"; break; end
    end
    reads = k;
  endtask

  task automatic waitDone(output bit seen);
    seen = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (opDone) begin seen = 1; break; end
    end
  endtask

  task automatic runOp(input int op, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                       input bit tog, input int nBusy, input int nDq5, input bit poke);
    bit seen, ePass;
    int eReads, eWr;
    string tag;
    logic [ADDR_W-1:0] ea;
    logic [7:0] ed;
    busy = nBusy;
    dq5At = nDq5;
    exp7 = (op == 0) ? d[7] : 1'b1;
    finalVal = (op == 0) ? d : 8'hFF;
    predict(tog, ePass, eReads, tag);
    @(negedge clk);
    readIdx = 0;
    wrCnt = 0;
    opCode = 2'(op); opAddr = a; opData = d; pollToggle = tog; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (poke) begin
      repeat (7) @(negedge clk);
      opCode = 2'd2; opAddr = '0; opData = 8'h00; pollToggle = ~tog; startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    waitDone(seen);
    check(seen, "R11 done seen", seen, 1);
    if (!seen) begin
      rstN = 1'b0; repeat (2) @(negedge clk); rstN = 1'b1;
      return;
    end
    check(opPass == ePass, tag, opPass, ePass);
    check(readIdx == eReads, {tag, " read count"}, readIdx, eReads);
    eWr = ((op == 0) ? 4 : 6) + (ePass ? 0 : 1);
    check(wrCnt == eWr, "R9 write count", wrCnt, eWr);
    for (int i = 0; i < ((op == 0) ? 4 : 6); i++) begin
      expectWrite(op, i, a, d, ea, ed);
      check(wrA[i] == ea, (op == 0) ? "R1 addr" : "R2 addr", int'(wrA[i]), int'(ea));
      check(wrD[i] == ed, (op == 0) ? "R1 data" : "R2 data", wrD[i], ed);
    end
    if (!ePass) check(wrD[eWr-1] == 8'hF0, "R9 reset data", wrD[eWr-1], 8'hF0);
    @(negedge clk);
    check(!opDone, "R11 pulse width", opDone, 0);
    if (poke) begin
      repeat (40) @(negedge clk);
      check(wrCnt == eWr, "R11 busy start ignored", wrCnt, eWr);
      check(!opDone && flashCeN, "R11 stays idle", flashCeN, 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(flashCeN && flashWeN && flashOeN, "R11 reset bus", {flashCeN, flashWeN, flashOeN}, 7);
    check(!flashDoutEn && !opDone, "R11 reset outputs", {flashDoutEn, opDone}, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int op = 0; op < 3; op++)
      for (int tog = 0; tog < 2; tog++)
        for (int b = 0; b < 10; b++)
          for (int q = 0; q < 3; q++) begin
            int nb = (b == 9) ? 40 : b;
            int nq = (q == 0) ? 1 : (q == 1) ? 4 : 99;
            logic [7:0] d = 8'(8'h5A ^ (b * 37 + q * 91 + op * 13));
            logic [ADDR_W-1:0] a = ADDR_W'(19'h32C41 + b * 19'h1000 + q * 7);
            runOp(op, a, d, tog[0], nb, nq, (b == 3 && q == 2));
          end
    check(minWeLow >= WLO, "R3 WE low width", minWeLow, WLO);
    check(minWeHigh >= WHI, "R3 WE high width", minWeHigh, WHI);
    check(badCe == 0 && badDrive == 0, "R3 CE and drive", badCe + badDrive, 0);
    check(minGap >= GAP, "R4 OE-to-WE gap", minGap, GAP);
    check(badOverlap == 0, "R4 WE/OE overlap", badOverlap, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule